// File: doc/BRIEF.md
# Flash Read Data Responder

This block forms the read side of a parallel NOR flash model. A command sequencer elsewhere in the device tracks the write cycles and reports which mode the device is in. This block takes each read strobe and its address. It then picks what the bus sees: the stored array word, an identification word, a byte from the device-description query table, or the live operation status. The result appears on a registered read port.

The query table is built inside the block from the geometry parameters. Only the low address byte selects an identification or query entry, and that byte is scaled by the bus width in bytes. During program and erase, the block keeps one toggle bit that flips on every status read. Host software polls this bit to see whether an operation is still running. A read made while the sequencer reports an unknown mode returns array data, and the block raises a one-cycle flag so that the sequencer can return to read-array mode.

Top module: `flrd_resp`

## Requirements
- R1: With mode code 0 (read array) or 1 (erase set-up pending), a strobed read returns `arr_data_i` as sampled at the strobe edge.
- R2: With mode code 2 (autoselect), word offsets 0x00 and 0x01 return identification words 0 and 1, zero-extended. Word k sits at `id_words_i[16k +: 16]`.
- R3: In autoselect, word offset 0x02 returns zero, which reports every sector as unprotected.
- R4: In autoselect, offsets 0x0E and 0x0F return identification words 2 and 3, unless that word is 0xFFFF. In that case, and for every offset other than 0x00, 0x01, 0x02, 0x0E and 0x0F, the array data is returned.
- R5: With mode code 4 (query), a read returns the table byte at the word offset, zero-extended. An offset of `QRY_LEN` (0x52) or more returns zero.
- R6: The query table holds 0x51, 0x52, 0x59 at offsets 0x10 to 0x12, and `ADDR_W` (log2 of the device size in bytes) at 0x27. Offsets 0x2D and 0x2E hold the sector count minus one, and 0x2F and 0x30 hold the sector size divided by 256, low byte first.
- R7: The word offset is `addr_i[7:0]` shifted right by log2(`BUS_BYTES`). Address bits above bit 7 do not affect the offset.
- R8: With mode code 3 (busy), a read returns `status_i` with bit 6 XORed with an internal toggle. The toggle is 0 after reset, flips after each busy read, and keeps its value across every other read and across idle cycles.
- R9: Mode codes 5 to 7 are invalid. A read in such a mode returns array data and raises `bad_mode_o` for the same cycle as `rvalid_o`.
- R10: `rdata_o`, `rvalid_o` and `bad_mode_o` are zero during reset. `rvalid_o` is high exactly in the cycle after each cycle with `rd_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Read strobe, one read per high cycle |
| addr_i | input | ADDR_W | Byte address of the read |
| mode_i | input | 3 | Mode code from the command sequencer |
| arr_data_i | input | DATA_W | Array word for `addr_i` |
| id_words_i | input | 4*ID_W | Four identification words, word 0 lowest |
| status_i | input | 8 | Status byte from the sequencer, before toggling |
| rdata_o | output | DATA_W | Registered read data |
| rvalid_o | output | 1 | Read data valid |
| bad_mode_o | output | 1 | The read just returned was made in an invalid mode |

## Verification
Every result is due one clock edge after its strobe. The selection logic samples mode, address and data at the strobe edge, and a single output register holds the result. The bench changes inputs on the falling edge and reads the ports on the next falling edge, which falls after the single register stage. The toggle bit changes at the same edge as the status read that uses it. A busy read therefore shows the value the toggle held before that edge, and back-to-back busy reads on consecutive cycles are expected to alternate. A read in another mode placed between two busy reads must not break the alternation, and neither may idle cycles.

// File: rtl/flrd_pkg.sv
package flrd_pkg;

  typedef enum logic [2:0] {
    MD_ARRAY  = 3'd0,
    MD_ERS_SU = 3'd1,
    MD_AUTOSL = 3'd2,
    MD_BUSY   = 3'd3,
    MD_QUERY  = 3'd4
  } rd_mode_e;

  function automatic int width_shift(int bus_bytes);
    if (bus_bytes == 4) return 2;
    if (bus_bytes == 2) return 1;
    return 0;
  endfunction

  // device-description byte at a given offset
  function automatic logic [7:0] qry_byte(int idx, int addr_w, int sect_aw);
    int nblk_m1;
    int sect_units;
    nblk_m1    = (1 << (addr_w - sect_aw)) - 1;
    sect_units = (1 << sect_aw) >> 8;
    case (idx)
      'h10: return 8'h51;
      'h11: return 8'h52;
      'h12: return 8'h59;
      'h13: return 8'h02;
      'h1b: return 8'h27;
      'h1c: return 8'h36;
      'h1f: return 8'h07;
      'h20: return 8'h04;
      'h21: return 8'h09;
      'h22: return 8'h0c;
      'h23: return 8'h01;
      'h24: return 8'h04;
      'h25: return 8'h0a;
      'h26: return 8'h0d;
      'h27: return 8'(addr_w);
      'h28: return 8'h02;
      'h2a: return 8'h05;
      'h2c: return 8'h01;
      'h2d: return 8'(nblk_m1);
      'h2e: return 8'(nblk_m1 >> 8);
      'h2f: return 8'(sect_units);
      'h30: return 8'(sect_units >> 8);
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/flrd_qry_tbl.sv
module flrd_qry_tbl #(
  parameter int QRY_LEN = 82,
  parameter int ADDR_W  = 24,
  parameter int SECT_AW = 16
) (
  input  logic [7:0] off_i,
  output logic [7:0] byte_o
);
  import flrd_pkg::*;

  localparam int QIW = (QRY_LEN > 1) ? $clog2(QRY_LEN) : 1;

  logic [7:0] tbl [QRY_LEN];

  for (genvar i = 0; i < QRY_LEN; i++) begin : g_ent
    assign tbl[i] = qry_byte(i, ADDR_W, SECT_AW);
  end

  always_comb begin
    if (int'(off_i) < QRY_LEN) byte_o = tbl[off_i[QIW-1:0]];
    else                       byte_o = 8'h00;
  end

endmodule

// File: rtl/flrd_id_sel.sv
module flrd_id_sel #(
  parameter int ID_W   = 16,
  parameter int DATA_W = 16
) (
  input  logic [7:0]        off_i,
  input  logic [4*ID_W-1:0] id_words_i,
  input  logic [DATA_W-1:0] arr_data_i,
  output logic [DATA_W-1:0] data_o
);

  logic [ID_W-1:0] id_w [4];

  for (genvar k = 0; k < 4; k++) begin : g_id
    assign id_w[k] = id_words_i[k*ID_W +: ID_W];
  end

  always_comb begin
    data_o = arr_data_i;
    case (off_i)
      8'h00: data_o = DATA_W'(id_w[0]);
      8'h01: data_o = DATA_W'(id_w[1]);
      8'h02: data_o = '0;
      // all-ones extended word means "absent": fall back to array
      8'h0e: if (id_w[2] != '1) data_o = DATA_W'(id_w[2]);
      8'h0f: if (id_w[3] != '1) data_o = DATA_W'(id_w[3]);
      default: data_o = arr_data_i;
    endcase
  end

endmodule

// File: rtl/flrd_stat_tgl.sv
module flrd_stat_tgl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_stat_i,
  input  logic [7:0] status_i,
  output logic [7:0] stat_o
);

  logic tgl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tgl_q <= 1'b0;
    else if (rd_stat_i) tgl_q <= ~tgl_q;
  end

  assign stat_o = status_i ^ {1'b0, tgl_q, 6'b0};

  // R8
  tgl_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stat_i |=> (tgl_q != $past(tgl_q)));

  // R8
  tgl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_stat_i |=> $stable(tgl_q));

endmodule

// File: rtl/flrd_resp.sv
module flrd_resp #(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int ID_W      = 16,
  parameter int BUS_BYTES = 2,
  parameter int SECT_AW   = 16,
  parameter int QRY_LEN   = 82
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        mode_i,
  input  logic [DATA_W-1:0] arr_data_i,
  input  logic [4*ID_W-1:0] id_words_i,
  input  logic [7:0]        status_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              bad_mode_o
);
  import flrd_pkg::*;

  localparam int WORD_SH = width_shift(BUS_BYTES);

  logic [7:0]        off;
  logic [7:0]        qry_b;
  logic [7:0]        stat_b;
  logic [DATA_W-1:0] id_d;
  logic [DATA_W-1:0] rd_d;
  logic              mode_bad;
  logic              rd_stat;
  logic              unused_hi;

  assign unused_hi = ^addr_i[ADDR_W-1:8];
  assign off       = addr_i[7:0] >> WORD_SH;
  assign mode_bad  = (mode_i > MD_QUERY);
  assign rd_stat   = rd_i && (mode_i == MD_BUSY);

  flrd_qry_tbl #(.QRY_LEN(QRY_LEN), .ADDR_W(ADDR_W), .SECT_AW(SECT_AW)) u_qry (
    .off_i  (off),
    .byte_o (qry_b)
  );

  flrd_id_sel #(.ID_W(ID_W), .DATA_W(DATA_W)) u_id (
    .off_i      (off),
    .id_words_i (id_words_i),
    .arr_data_i (arr_data_i),
    .data_o     (id_d)
  );

  flrd_stat_tgl u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_stat_i (rd_stat),
    .status_i  (status_i),
    .stat_o    (stat_b)
  );

  always_comb begin
    case (mode_i)
      MD_AUTOSL: rd_d = id_d;
      MD_BUSY:   rd_d = DATA_W'(stat_b);
      MD_QUERY:  rd_d = DATA_W'(qry_b);
      default:   rd_d = arr_data_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o    <= '0;
      rvalid_o   <= 1'b0;
      bad_mode_o <= 1'b0;
    end else begin
      rvalid_o   <= rd_i;
      bad_mode_o <= rd_i && mode_bad;
      if (rd_i) rdata_o <= rd_d;
    end
  end

  // R10
  rvalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);

  // R10
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o);

  // R9
  bad_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_mode_o |-> rvalid_o);

  // R9
  bad_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && mode_i > 3'd4) |=> bad_mode_o);

  // R1
  arr_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && mode_i <= 3'd1) |=> (rdata_o == $past(arr_data_i)));

  // R5
  qry_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && mode_i == 3'd4 && int'(off) >= QRY_LEN) |=> (rdata_o == '0));

endmodule

// File: tb/flrd_resp_tb_top.sv
module flrd_resp_tb_top;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd = 1'b0;
  logic [23:0] addr = '0;
  logic [2:0]  mode = '0;
  logic [15:0] arr = '0;
  logic [63:0] ids = {16'hffff, 16'h2222, 16'h227e, 16'h0001};
  logic [7:0]  stat = 8'h80;
  logic [15:0] rdata;
  logic        rvalid;
  logic        bad;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  flrd_resp dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .rd_i(rd), .addr_i(addr), .mode_i(mode),
    .arr_data_i(arr), .id_words_i(ids), .status_i(stat),
    .rdata_o(rdata), .rvalid_o(rvalid), .bad_mode_o(bad)
  );

  // {mode, addr, arr, expected, req}
  localparam int NV = 19;
  localparam logic [66:0] VECS [NV] = '{
    {3'd0, 24'h000100, 16'h1234, 16'h1234, 8'd1},  // R1 array
    {3'd1, 24'h000010, 16'hbeef, 16'hbeef, 8'd1},  // R1 erase set-up
    {3'd2, 24'h000000, 16'haaaa, 16'h0001, 8'd2},  // R2 id0
    {3'd2, 24'h000002, 16'haaaa, 16'h227e, 8'd2},  // R2 id1
    {3'd2, 24'h000004, 16'h5555, 16'h0000, 8'd3},  // R3 protect
    {3'd2, 24'h00001c, 16'h6666, 16'h2222, 8'd4},  // R4 id2
    {3'd2, 24'h00001e, 16'h7777, 16'h7777, 8'd4},  // R4 id3 all-ones
    {3'd2, 24'h000006, 16'h3333, 16'h3333, 8'd4},  // R4 other offset
    {3'd2, 24'h000100, 16'h9999, 16'h0001, 8'd7},  // R7 high bits ignored
    {3'd4, 24'h000020, 16'h1111, 16'h0051, 8'd6},  // R6 Q
    {3'd4, 24'h000022, 16'h1111, 16'h0052, 8'd6},  // R6 R
    {3'd4, 24'h000024, 16'h1111, 16'h0059, 8'd6},  // R6 Y
    {3'd4, 24'h00004e, 16'h1111, 16'h0018, 8'd6},  // R6 size
    {3'd4, 24'h00005a, 16'h1111, 16'h00ff, 8'd6},  // R6 sectors-1
    {3'd4, 24'h000060, 16'h1111, 16'h0001, 8'd6},  // R6 sector size hi
    {3'd4, 24'h0000a4, 16'hcccc, 16'h0000, 8'd5},  // R5 first beyond end
    {3'd4, 24'h0000fe, 16'hcccc, 16'h0000, 8'd5},  // R5 far beyond
    {3'd3, 24'h000000, 16'hdddd, 16'h0080, 8'd8},  // R8 toggle 0
    {3'd3, 24'h000000, 16'hdddd, 16'h00c0, 8'd8}   // R8 toggle 1
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_one(logic [2:0] m, logic [23:0] a, logic [15:0] d);
    mode = m; addr = a; arr = d; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: got hang expected finish");
    $display("  test done: total=%0d bad=%0d", total, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 rdata reset", 32'(rdata), 32'h0);
    check("R10 rvalid reset", 32'(rvalid), 32'h0);
    check("R10 bad reset", 32'(bad), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    // back-to-back vector walk
    for (int i = 0; i < NV; i++) begin
      mode = VECS[i][66:64]; addr = VECS[i][63:40]; arr = VECS[i][39:24];
      rd = 1'b1;
      @(negedge clk);
      check($sformatf("R%0d vec %0d", VECS[i][7:0], i),
            32'(rdata), 32'(VECS[i][23:8]));
    end
    rd = 1'b0;
    @(negedge clk);
    check("R10 no strobe no valid", 32'(rvalid), 32'h0);

    // R8: other-mode read and idle cycles must not touch the toggle
    read_one(3'd4, 24'h000020, 16'h0);
    check("R5 query between status", 32'(rdata), 32'h51);
    repeat (3) @(negedge clk);
    read_one(3'd3, 24'h0, 16'h0);
    check("R8 toggle kept across other reads", 32'(rdata), 32'h80);
    read_one(3'd3, 24'h0, 16'h0);
    check("R8 toggle flips again", 32'(rdata), 32'hc0);

    // R9 invalid mode
    read_one(3'd7, 24'h000040, 16'h4242);
    check("R9 invalid mode data", 32'(rdata), 32'h4242);
    check("R9 invalid mode flag", 32'(bad), 32'h1);
    check("R10 valid with flag", 32'(rvalid), 32'h1);
    @(negedge clk);
    check("R9 flag is a pulse", 32'(bad), 32'h0);
    read_one(3'd5, 24'h000002, 16'h0bad);
    check("R9 mode 5 data", 32'(rdata), 32'h0bad);
    check("R9 mode 5 flag", 32'(bad), 32'h1);
    read_one(3'd0, 24'h000002, 16'h0123);
    check("R9 valid mode no flag", 32'(bad), 32'h0);

    // R4 id2 absent falls back
    ids[47:32] = 16'hffff;
    read_one(3'd2, 24'h00001c, 16'h5a5a);
    check("R4 id2 all-ones fallback", 32'(rdata), 32'h5a5a);

    // R8 reset clears toggle (toggle currently 0; move to 1 first)
    read_one(3'd3, 24'h0, 16'h0);
    check("R8 pre-reset read", 32'(rdata), 32'h80);
    rst_ni = 1'b0;
    @(negedge clk);
    check("R10 rvalid in reset", 32'(rvalid), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    read_one(3'd3, 24'h0, 16'h0);
    check("R8 toggle zero after reset", 32'(rdata), 32'h80);

    $display("  test done: total=%0d bad=%0d", total, fails);
    $finish;
  end

endmodule